// File: doc/BRIEF.md
# Track Jump Brake Signal Generator

This block drives the tracking-off control of an optical pickup servo while the pickup jumps across tracks. It takes two digital inputs from the front end. The first is the zero-cross comparator output of the tracking error. The second is the mirror detector, which reads high over the unrecorded mirror surface and low over the pitted area. Each level change of the tracking error comparator is treated as a sampling event, and the mirror detector is read at that moment.

When the beam has just entered the pitted area, the output goes high and cuts the tracking drive. When the beam has just returned to the mirror surface, the output drops low again, but only while the gain-enhance flag (active low) is asserted. The result is that a brake is applied according to the direction in which the beam is sweeping. Outside a jump, the output is held low.

Both asynchronous inputs pass through a synchronizer of configurable depth before any edge detection. Either polarity of comparator edge is accepted, so a jump toward the inner edge of the disc and a jump toward the outer edge are handled in the same way.

Top module: `jump_brake_gen`

## Requirements
- R1: While `rst_n` is low, `toff_o` is low. It is forced low at once, without waiting for a clock edge.
- R2: With the default two-stage synchronizer, a level change on `tes_i` that is set up before rising clock edge 1 gives its `toff_o` update after rising clock edge 3. `hfl_i` has the same delay, so the value of `hfl_i` applied together with the `tes_i` change is the value that gets sampled.
- R3: During a jump, a `tes_i` edge that samples `hfl_i` = 0 (pitted area) sets `toff_o` to 1.
- R4: During a jump, a `tes_i` edge that samples `hfl_i` = 1 (mirror) while `tgl_n_i` = 0 (gain enhanced) clears `toff_o` to 0.
- R5: During a jump, a `tes_i` edge that samples `hfl_i` = 1 while `tgl_n_i` = 1 leaves `toff_o` unchanged.
- R6: A change on `hfl_i` with no `tes_i` edge leaves `toff_o` unchanged.
- R7: While `jump_act_i` = 0, `toff_o` is low and `tes_i` edges have no effect.
- R8: Rising and falling edges of `tes_i` act identically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tes_i | input | 1 | Tracking error zero-cross comparator output (asynchronous) |
| hfl_i | input | 1 | Mirror detect: 1 means mirror, 0 means pits (asynchronous) |
| jump_act_i | input | 1 | High during a track jump (synchronous) |
| tgl_n_i | input | 1 | Gain-enhance flag: 0 means enhanced (synchronous) |
| toff_o | output | 1 | Tracking-off / brake control |

## Verification
The bench changes `hfl_i` without any comparator edge. A design that gates the output directly from the mirror detector would follow that change and fail. It also samples the mirror value with high gain selected, which catches a design that releases the brake without checking the gain flag. Comparator edges of both polarities are applied, which exposes an edge detector that only sees rising edges. Edges are also applied while no jump is active, and the output latency is counted edge by edge, so a missing or extra synchronizer stage shows up. Finally, reset is asserted while the output is high, to catch a reset that is synchronous or absent.

// File: rtl/jb_pkg.sv
package jb_pkg;

  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef enum logic [1:0] {
    ACT_HOLD    = 2'd0,
    ACT_CUT     = 2'd1,
    ACT_RELEASE = 2'd2
  } brake_act_e;

  // Decide what a sampling event does to the brake output.
  function automatic brake_act_e brake_action(input logic edge_seen,
                                              input logic on_mirror,
                                              input logic gain_boost_n);
    brake_act_e act;
    act = ACT_HOLD;
    if (edge_seen) begin
      if (!on_mirror)         act = ACT_CUT;
      else if (!gain_boost_n) act = ACT_RELEASE;
    end
    return act;
  endfunction

endpackage

// File: rtl/jb_sync.sv
module jb_sync #(
  parameter int unsigned STAGES = jb_pkg::SYNC_STAGES_DEF,
  parameter int unsigned WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/jb_edge_det.sv
module jb_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic any_edge_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign any_edge_o = level_i ^ prev_q;

endmodule

// File: rtl/jb_brake_reg.sv
module jb_brake_reg
  import jb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic jump_act_i,
  input  logic edge_i,
  input  logic mirror_i,
  input  logic gain_boost_n_i,
  output logic toff_o
);

  brake_act_e act;
  logic       toff_q;

  assign act = brake_action(edge_i, mirror_i, gain_boost_n_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      toff_q <= 1'b0;
    end else if (!jump_act_i) begin
      toff_q <= 1'b0;
    end else begin
      unique case (act)
        ACT_CUT:     toff_q <= 1'b1;
        ACT_RELEASE: toff_q <= 1'b0;
        default:     toff_q <= toff_q;
      endcase
    end
  end

  assign toff_o = toff_q;

endmodule

// File: rtl/jump_brake_gen.sv
module jump_brake_gen #(
  parameter int unsigned SYNC_STAGES = jb_pkg::SYNC_STAGES_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tes_i,
  input  logic hfl_i,
  input  logic jump_act_i,
  input  logic tgl_n_i,
  output logic toff_o
);

  localparam int unsigned NSIG = 2;

  logic [NSIG-1:0] raw_in;
  logic [NSIG-1:0] synced;
  logic            tes_sync;
  logic            hfl_sync;
  logic            tes_edge;

  assign raw_in   = {hfl_i, tes_i};
  assign tes_sync = synced[0];
  assign hfl_sync = synced[1];

  jb_sync #(.STAGES(SYNC_STAGES), .WIDTH(NSIG)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_in),
    .sync_o  (synced)
  );

  jb_edge_det u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .level_i    (tes_sync),
    .any_edge_o (tes_edge)
  );

  jb_brake_reg u_brake (
    .clk            (clk),
    .rst_n          (rst_n),
    .jump_act_i     (jump_act_i),
    .edge_i         (tes_edge),
    .mirror_i       (hfl_sync),
    .gain_boost_n_i (tgl_n_i),
    .toff_o         (toff_o)
  );

endmodule

// File: rtl/jb_checker.sv
module jb_checker (
  input logic clk,
  input logic rst_n,
  input logic jump_act_i,
  input logic tgl_n_i,
  input logic tes_edge,
  input logic hfl_sync,
  input logic toff_o
);

  // R1
  p_reset_low_r1: assert property (@(posedge clk) !rst_n |=> !toff_o);

  p_cut_on_pits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_act_i && tes_edge && !hfl_sync) |=> toff_o);

  p_release_on_mirror_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_act_i && tes_edge && hfl_sync && !tgl_n_i) |=> !toff_o);

  p_hold_high_gain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_act_i && tes_edge && hfl_sync && tgl_n_i) |=> $stable(toff_o));

  p_hold_no_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_act_i && !tes_edge) |=> $stable(toff_o));

  p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !jump_act_i |=> !toff_o);

endmodule

bind jump_brake_gen jb_checker u_jb_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .jump_act_i (jump_act_i),
  .tgl_n_i    (tgl_n_i),
  .tes_edge   (tes_edge),
  .hfl_sync   (hfl_sync),
  .toff_o     (toff_o)
);

// File: tb/test_jump_brake_gen.sv
module test_jump_brake_gen;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tes = 1'b0, hfl = 1'b0, jump = 1'b0, tgl_n = 1'b1;
  logic toff;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  jump_brake_gen i_jump_brake_gen (
    .clk(clk), .rst_n(rst_n), .tes_i(tes), .hfl_i(hfl),
    .jump_act_i(jump), .tgl_n_i(tgl_n), .toff_o(toff)
  );

  // vector: {tes, hfl, jump, tgl_n, expected toff}
  localparam int NVEC = 12;
  localparam logic [4:0] VEC [NVEC] = '{
    5'b0_1_1_0_0, // R6 hfl moves, no edge
    5'b1_1_1_0_0, // R4 rising edge on mirror, gain enhanced
    5'b1_0_1_0_0, // R6 hfl drops, no edge
    5'b0_0_1_0_1, // R3 R8 falling edge on pits
    5'b0_1_1_0_1, // R6 hfl rises, no edge
    5'b1_1_1_1_1, // R5 mirror, high gain: hold
    5'b0_1_1_0_0, // R4 R8 falling edge release
    5'b1_0_1_1_1, // R3 rising edge on pits
    5'b1_0_0_1_0, // R7 jump ends
    5'b0_0_0_1_0, // R7 edge outside jump ignored
    5'b0_0_1_1_0, // R6 R7 jump again, no edge
    5'b1_0_1_0_1  // R3 rising edge cuts
  };
  localparam int VREQ [NVEC] = '{6, 4, 6, 3, 6, 5, 4, 3, 7, 7, 6, 3};

  task automatic check(input string req, input logic exp);
    checks++;
    if (toff !== exp) begin
      fails++;
      $display("FAIL %s: toff=%b expected=%b at %0t", req, toff, exp, $time);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      {tes, hfl, jump, tgl_n} = VEC[i][4:1];
      repeat (4) @(negedge clk);
      check($sformatf("R%0d vec%0d", VREQ[i], i), VEC[i][0]);
    end

    // R2: latency, toff currently 1; release on mirror with gain enhanced
    hfl = 1'b1; tgl_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R6", 1'b1);
    tes = ~tes;
    repeat (2) @(negedge clk);
    check("R2 before third edge", 1'b1);
    @(negedge clk);
    check("R2 after third edge", 1'b0);

    // R2: hfl applied together with tes edge is the one sampled
    hfl = 1'b0; tes = ~tes;
    repeat (3) @(negedge clk);
    check("R2 aligned sample", 1'b1);

    // R1: asynchronous reset while high
    @(posedge clk); #1;
    rst_n = 1'b0;
    #0.5;
    check("R1 async", 1'b0);
    @(negedge clk);
    check("R1 held", 1'b0);
    tes = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule